// File: doc/BRIEF.md
# Block Check Engine (16-bit CRC and 8-bit LRC)

This block keeps running check values over the bytes of one block on a smart-card character link. A 16-bit CRC (polynomial 0x1021, preset 0xFFFF, most significant bit first) and an 8-bit longitudinal check (XOR of all bytes) run side by side. Each one has its own enable. A block-start pulse clears both. On the receive side, the block raises an OK flag when the running value reaches the expected residue after the check bytes have passed through it.

On the transmit side, the block supplies the check bytes that follow the payload. When append is enabled and the transmit FIFO reports empty, the engine takes a snapshot of the current check value. It then presents that value one byte per request from the transmitter: the CRC high byte first, or the single LRC byte when only the LRC is enabled.

Three configuration bits adjust the CRC. One reverses the bit order of each input byte before the update. One reverses the bits inside each output byte. One inverts the whole output value.

Top module: `blkchk_engine`

## Requirements
- R1: After reset, and after a block-start pulse without a byte strobe, the CRC register holds 0xFFFF and the LRC holds 0x00. With the output options off, `crc_val` reads 0xFFFF and `lrc_val` reads 0x00. The append outputs are idle after reset.
- R2: With `crc_en`=1, each `byte_vld` strobe updates the CRC with the byte, MSB first, using polynomial 0x1021. The ASCII string "123456789" gives 0x29B1. Without a strobe the value holds.
- R3: With `lrc_en`=1, each strobe XORs the byte into the LRC. "123456789" gives 0x31. Without a strobe the value holds.
- R4: With `in_rev`=1, each byte has its bits reversed (bit 7 swapped with bit 0, and so on) before the CRC update. The LRC always uses the byte unchanged.
- R5: With `out_rev`=1, `crc_val` reverses the bits inside each of its two bytes. A raw value of 0x29B1 reads 0x948D.
- R6: With `out_inv`=1, `crc_val` is the bitwise inverse of the value it would otherwise show. Inversion is applied after the per-byte reversal.
- R7: `lrc_ok` is 1 exactly when `lrc_en`=1 and the running LRC equals 0x00.
- R8: `crc_ok` is 1 exactly when `crc_en`=1 and the raw CRC register equals the residue: 0x0000 when `out_inv`=0, or 0x1D0F when `out_inv`=1.
- R9: With `crc_en`=0, strobes leave the CRC unchanged and `crc_ok` is 0. With `lrc_en`=0, strobes leave the LRC unchanged and `lrc_ok` is 0.
- R10: When `blk_start` and `byte_vld` are both high in the same cycle, that byte is the first byte of the new block. It is applied to the preset values.
- R11: The append sequence starts when `app_en`=1, `tx_empty`=1, `crc_en`=1 and the engine is idle. One cycle later, `app_vld`=1 and `app_byte` shows the high byte of `crc_val` as it stood at the start. Each cycle with `app_req`=1 consumes one byte. After the low byte is consumed, `app_done`=1 and `app_vld`=0, and this holds until `blk_start`. Bytes that arrive during the sequence do not change the bytes being appended.
- R12: With `crc_en`=0 and `lrc_en`=1, the sequence appends the single LRC byte and then sets `app_done`. With both enables at 0, no sequence starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Clears both accumulators and the append sequencer |
| byte_vld | input | 1 | Strobe for `byte_in` |
| byte_in | input | 8 | Byte of the block |
| crc_en | input | 1 | Enables the CRC |
| lrc_en | input | 1 | Enables the LRC |
| in_rev | input | 1 | Reverses input bits before the CRC update |
| out_rev | input | 1 | Reverses bits within each CRC output byte |
| out_inv | input | 1 | Inverts the CRC output |
| app_en | input | 1 | Enables check-byte append |
| tx_empty | input | 1 | Transmit FIFO is empty |
| app_req | input | 1 | Transmitter takes the presented byte |
| crc_val | output | 16 | CRC value after the output options |
| lrc_val | output | 8 | Running LRC |
| crc_ok | output | 1 | CRC equals the residue |
| lrc_ok | output | 1 | LRC equals zero |
| app_vld | output | 1 | `app_byte` holds a check byte |
| app_byte | output | 8 | Check byte to transmit |
| app_done | output | 1 | All check bytes have been taken |

## Verification
The nine-byte ASCII string pins the CRC and LRC to fixed values that do not depend on any model, so a wrong polynomial, bit order or preset shows up directly. Blocks that end with their own check bytes, once plain and once inverted, separate the two residues. A trailing LRC byte exercises the zero test. Random byte streams, with random strobe gaps, block starts and all combinations of the reversal, inversion and enable options, are compared each cycle against a bench model. This exposes mistakes in the order of options and in the gating by the enables. Directed append runs, covering CRC mode, LRC-only mode, no-check mode, and bytes injected during the sequence, separate the byte order and the snapshot behaviour.

// File: rtl/blkchk_pkg.sv
package blkchk_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    APP_IDLE = 2'd0,
    APP_SEND = 2'd1,
    APP_DONE = 2'd2
  } app_state_e;

  // mirror the bit order of one byte
  function automatic byte_t rev_byte(input byte_t b);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/blkchk_crc.sv
module blkchk_crc
  import blkchk_pkg::*;
#(
  parameter int                CRC_W     = 16,
  parameter logic [CRC_W-1:0]  POLY      = 16'h1021,
  parameter logic [CRC_W-1:0]  PRESET    = 16'hFFFF,
  parameter logic [CRC_W-1:0]  RES_PLAIN = 16'h0000,
  parameter logic [CRC_W-1:0]  RES_INV   = 16'h1D0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             byte_vld,
  input  byte_t            byte_in,
  input  logic             crc_en,
  input  logic             in_rev,
  input  logic             out_rev,
  input  logic             out_inv,
  output logic [CRC_W-1:0] crc_val,
  output logic             crc_ok
);

  localparam int NBYTES = CRC_W / BYTE_W;

  logic [CRC_W-1:0] crc_q, crc_d, base;
  logic [CRC_W-1:0] flipped;
  logic             crc_ld;
  byte_t            din_m;

  // one byte, most significant bit first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input byte_t d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  assign din_m  = in_rev ? rev_byte(byte_in) : byte_in;
  assign crc_ld = blk_start | (byte_vld & crc_en);

  always_comb begin
    base  = blk_start ? PRESET : crc_q;
    crc_d = base;
    if (byte_vld && crc_en) crc_d = crc_step(base, din_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= PRESET;
    else if (crc_ld) crc_q <= crc_d;
  end

  // output shaping: per-byte reversal, then inversion
  for (genvar g = 0; g < NBYTES; g++) begin : g_oflip
    assign flipped[g*BYTE_W +: BYTE_W] =
      out_rev ? rev_byte(crc_q[g*BYTE_W +: BYTE_W]) : crc_q[g*BYTE_W +: BYTE_W];
  end

  assign crc_val = out_inv ? ~flipped : flipped;
  assign crc_ok  = crc_en && (crc_q == (out_inv ? RES_INV : RES_PLAIN));

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !blk_start) |=> $stable(crc_q)); // R2
  AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !byte_vld) |=> (crc_q == PRESET)); // R1
  AST_CRC_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!crc_en && !blk_start) |=> $stable(crc_q)); // R9
  AST_CRC_OK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> crc_en); // R8

endmodule

// File: rtl/blkchk_lrc.sv
module blkchk_lrc
  import blkchk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  blk_start,
  input  logic  byte_vld,
  input  byte_t byte_in,
  input  logic  lrc_en,
  output byte_t lrc_val,
  output logic  lrc_ok
);

  byte_t lrc_q, lrc_d;
  logic  lrc_ld;

  assign lrc_ld = blk_start | (byte_vld & lrc_en);

  always_comb begin
    lrc_d = blk_start ? '0 : lrc_q;
    if (byte_vld && lrc_en) lrc_d = lrc_d ^ byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lrc_q <= '0;
    else if (lrc_ld) lrc_q <= lrc_d;
  end

  assign lrc_val = lrc_q;
  assign lrc_ok  = lrc_en && (lrc_q == '0);

  AST_LRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !byte_vld) |=> (lrc_val == '0)); // R1
  AST_LRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !blk_start) |=> $stable(lrc_q)); // R3
  AST_LRC_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lrc_en && !blk_start) |=> $stable(lrc_q)); // R9

endmodule

// File: rtl/blkchk_append.sv
module blkchk_append
  import blkchk_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             app_en,
  input  logic             tx_empty,
  input  logic             crc_en,
  input  logic             lrc_en,
  input  logic [CRC_W-1:0] crc_val,
  input  byte_t            lrc_val,
  input  logic             app_req,
  output logic             app_vld,
  output byte_t            app_byte,
  output logic             app_done
);

  localparam int NBYTES = CRC_W / BYTE_W;
  localparam int LEFT_W = $clog2(NBYTES + 1);

  app_state_e       state_q, state_d;
  logic [CRC_W-1:0] snap_q, snap_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic             go;

  assign go = app_en && tx_empty && (crc_en || lrc_en);

  always_comb begin
    state_d = state_q;
    snap_d  = snap_q;
    left_d  = left_q;
    if (blk_start) begin
      state_d = APP_IDLE;
      left_d  = '0;
    end else begin
      unique case (state_q)
        APP_IDLE: if (go) begin
          state_d = APP_SEND;
          if (crc_en) begin
            snap_d = crc_val;
            left_d = LEFT_W'(NBYTES);
          end else begin
            snap_d = {lrc_val, {(CRC_W-BYTE_W){1'b0}}};
            left_d = LEFT_W'(1);
          end
        end
        APP_SEND: if (app_req) begin
          snap_d = snap_q << BYTE_W;
          left_d = left_q - LEFT_W'(1);
          if (left_q == LEFT_W'(1)) state_d = APP_DONE;
        end
        APP_DONE: ;
        default: state_d = APP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= APP_IDLE;
      snap_q  <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      snap_q  <= snap_d;
      left_q  <= left_d;
    end
  end

  assign app_vld  = (state_q == APP_SEND);
  assign app_done = (state_q == APP_DONE);
  assign app_byte = snap_q[CRC_W-1 -: BYTE_W];

  AST_APP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(app_vld && app_done)); // R11
  AST_APP_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (app_done && !blk_start) |=> app_done); // R11
  AST_APP_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(app_vld) |-> $past(tx_empty)); // R11
  AST_APP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    app_vld |-> (left_q != '0)); // R12

endmodule

// File: rtl/blkchk_engine.sv
module blkchk_engine
  import blkchk_pkg::*;
#(
  parameter int                CRC_W     = 16,
  parameter logic [CRC_W-1:0]  POLY      = 16'h1021,
  parameter logic [CRC_W-1:0]  PRESET    = 16'hFFFF,
  parameter logic [CRC_W-1:0]  RES_PLAIN = 16'h0000,
  parameter logic [CRC_W-1:0]  RES_INV   = 16'h1D0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             crc_en,
  input  logic             lrc_en,
  input  logic             in_rev,
  input  logic             out_rev,
  input  logic             out_inv,
  input  logic             app_en,
  input  logic             tx_empty,
  input  logic             app_req,
  output logic [CRC_W-1:0] crc_val,
  output logic [7:0]       lrc_val,
  output logic             crc_ok,
  output logic             lrc_ok,
  output logic             app_vld,
  output logic [7:0]       app_byte,
  output logic             app_done
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  blkchk_crc #(
    .CRC_W(CRC_W), .POLY(POLY), .PRESET(PRESET),
    .RES_PLAIN(RES_PLAIN), .RES_INV(RES_INV)
  ) u_crc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .blk_start(blk_start),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .crc_en   (crc_en),
    .in_rev   (in_rev),
    .out_rev  (out_rev),
    .out_inv  (out_inv),
    .crc_val  (crc_val),
    .crc_ok   (crc_ok)
  );

  blkchk_lrc u_lrc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .blk_start(blk_start),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .lrc_en   (lrc_en),
    .lrc_val  (lrc_val),
    .lrc_ok   (lrc_ok)
  );

  blkchk_append #(.CRC_W(CRC_W)) u_app (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .blk_start(blk_start),
    .app_en   (app_en),
    .tx_empty (tx_empty),
    .crc_en   (crc_en),
    .lrc_en   (lrc_en),
    .crc_val  (crc_val),
    .lrc_val  (lrc_val),
    .app_req  (app_req),
    .app_vld  (app_vld),
    .app_byte (app_byte),
    .app_done (app_done)
  );

endmodule

// File: tb/tb_blkchk_engine.sv
`timescale 1ns/1ps
module tb_blkchk_engine;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, blk_start, byte_vld, crc_en, lrc_en, in_rev, out_rev, out_inv;
  logic app_en, tx_empty, app_req;
  logic [7:0]  byte_in;
  logic [15:0] crc_val;
  logic [7:0]  lrc_val, app_byte;
  logic crc_ok, lrc_ok, app_vld, app_done;

  blkchk_engine dut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .byte_vld(byte_vld),
    .byte_in(byte_in), .crc_en(crc_en), .lrc_en(lrc_en), .in_rev(in_rev),
    .out_rev(out_rev), .out_inv(out_inv), .app_en(app_en), .tx_empty(tx_empty),
    .app_req(app_req), .crc_val(crc_val), .lrc_val(lrc_val), .crc_ok(crc_ok),
    .lrc_ok(lrc_ok), .app_vld(app_vld), .app_byte(app_byte), .app_done(app_done)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] mc;
  logic [7:0]  ml;

  function automatic logic [7:0] m_rev(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  function automatic logic [15:0] m_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  function automatic logic [15:0] m_out(input logic [15:0] r, input logic rv, input logic iv);
    logic [15:0] v;
    v = rv ? {m_rev(r[15:8]), m_rev(r[7:0])} : r;
    return iv ? ~v : v;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model update from the inputs applied this cycle, then advance one cycle
  task automatic cyc();
    if (rst_n && blk_start) begin mc = 16'hFFFF; ml = 8'h00; end
    if (rst_n && byte_vld) begin
      if (crc_en) mc = m_step(mc, in_rev ? m_rev(byte_in) : byte_in);
      if (lrc_en) ml = ml ^ byte_in;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    byte_vld = 1'b1; byte_in = b;
    cyc();
    byte_vld = 1'b0;
  endtask

  task automatic new_block();
    blk_start = 1'b1;
    cyc();
    blk_start = 1'b0;
  endtask

  task automatic check_model(input string req);
    chk({req, " crc_val"}, crc_val, m_out(mc, out_rev, out_inv));
    chk({req, " lrc_val"}, {8'h00, lrc_val}, {8'h00, ml});
    chk({req, " crc_ok"}, {15'd0, crc_ok},
        {15'd0, crc_en && (mc == (out_inv ? 16'h1D0F : 16'h0000))});
    chk({req, " lrc_ok"}, {15'd0, lrc_ok}, {15'd0, lrc_en && (ml == 8'h00)});
  endtask

  task automatic send_str();
    for (int i = 0; i < 9; i++) send(8'h31 + 8'(i));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] hi, lo;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; blk_start = 0; byte_vld = 0; byte_in = 0;
    crc_en = 0; lrc_en = 0; in_rev = 0; out_rev = 0; out_inv = 0;
    app_en = 0; tx_empty = 0; app_req = 0;
    mc = 16'hFFFF; ml = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 reset crc_val", crc_val, 16'hFFFF);
    chk("R1 reset lrc_val", {8'h00, lrc_val}, 16'h0000);
    chk("R1 reset app_vld", {15'd0, app_vld}, 16'd0);
    chk("R1 reset app_done", {15'd0, app_done}, 16'd0);

    // R2 R3 fixed check string
    crc_en = 1; lrc_en = 1;
    new_block();
    send_str();
    chk("R2 check string crc", crc_val, 16'h29B1);
    chk("R3 check string lrc", {8'h00, lrc_val}, 16'h0031);
    cyc(); cyc();
    chk("R2 hold without strobe", crc_val, 16'h29B1);
    out_rev = 1; #1;
    chk("R5 per-byte reversal", crc_val, 16'h948D);
    out_inv = 1; #1;
    chk("R6 reversal then inversion", crc_val, 16'h6B72);
    out_rev = 0; #1;
    chk("R6 inversion", crc_val, 16'hD64E);
    out_inv = 0; #1;

    // R1 block start clears
    new_block();
    chk("R1 start crc", crc_val, 16'hFFFF);
    chk("R1 start lrc", {8'h00, lrc_val}, 16'h0000);

    // R8 plain residue
    send_str();
    chk("R8 ok low before check bytes", {15'd0, crc_ok}, 16'd0);
    send(8'h29); send(8'hB1);
    chk("R8 plain residue ok", {15'd0, crc_ok}, 16'd1);

    // R8 inverted residue
    out_inv = 1;
    new_block();
    send_str();
    send(8'hD6); send(8'h4E);
    chk("R8 inverted residue ok", {15'd0, crc_ok}, 16'd1);
    out_inv = 0;

    // R7 LRC zero
    crc_en = 0;
    new_block();
    send_str();
    chk("R7 lrc_ok low", {15'd0, lrc_ok}, 16'd0);
    send(8'h31);
    chk("R7 lrc_ok after check byte", {15'd0, lrc_ok}, 16'd1);

    // R9 disabled CRC holds and ok gated
    chk("R9 crc_ok gated", {15'd0, crc_ok}, 16'd0);
    chk("R9 crc held", crc_val, 16'hFFFF);
    lrc_en = 0; crc_en = 1;
    send(8'h5A);
    chk("R9 lrc held when disabled", {8'h00, lrc_val}, 16'h0000);
    chk("R9 lrc_ok gated", {15'd0, lrc_ok}, 16'd0);

    // R4 input reversal
    lrc_en = 1; in_rev = 1;
    new_block();
    send(8'h01);
    chk("R4 in_rev crc", crc_val, m_step(16'hFFFF, 8'h80));
    chk("R4 lrc unaffected", {8'h00, lrc_val}, 16'h0001);
    in_rev = 0;

    // R10 start with strobe
    send(8'h77);
    blk_start = 1; byte_vld = 1; byte_in = 8'h31;
    cyc();
    blk_start = 0; byte_vld = 0;
    chk("R10 start+strobe crc", crc_val, m_step(16'hFFFF, 8'h31));
    chk("R10 start+strobe lrc", {8'h00, lrc_val}, 16'h0031);

    // random streams against model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    new_block();
    for (int seg = 0; seg < 12; seg++) begin
      crc_en = $urandom_range(0, 3) != 0; lrc_en = $urandom_range(0, 3) != 0;
      in_rev = $urandom_range(0, 1); out_rev = $urandom_range(0, 1);
      out_inv = $urandom_range(0, 1);
      for (int k = 0; k < 40; k++) begin
        blk_start = ($urandom_range(0, 19) == 0);
        byte_vld  = $urandom_range(0, 2) != 0;
        byte_in   = 8'($urandom);
        cyc();
        check_model("R2 R3 R10 random");
      end
      blk_start = 0; byte_vld = 0;
    end
    crc_en = 1; lrc_en = 1; in_rev = 0; out_rev = 0; out_inv = 0;

    // R11 CRC append with snapshot
    new_block();
    send_str();
    app_en = 1; tx_empty = 1;
    cyc();
    chk("R11 app_vld after start", {15'd0, app_vld}, 16'd1);
    chk("R11 high byte first", {8'h00, app_byte}, 16'h0029);
    send(8'hEE);
    chk("R11 snapshot held", {8'h00, app_byte}, 16'h0029);
    app_req = 1;
    cyc();
    chk("R11 low byte", {8'h00, app_byte}, 16'h00B1);
    cyc();
    app_req = 0;
    chk("R11 done after two", {15'd0, app_done}, 16'd1);
    chk("R11 vld low when done", {15'd0, app_vld}, 16'd0);
    cyc(); cyc();
    chk("R11 done holds", {15'd0, app_done}, 16'd1);
    app_en = 0;
    new_block();
    chk("R11 start clears done", {15'd0, app_done}, 16'd0);

    // R11 inverted and flipped output appended
    out_inv = 1; out_rev = 1;
    send_str();
    hi = 8'h6B; lo = 8'h72;
    app_en = 1;
    cyc();
    chk("R11 shaped high byte", {8'h00, app_byte}, {8'h00, hi});
    app_req = 1; cyc(); app_req = 0;
    chk("R11 shaped low byte", {8'h00, app_byte}, {8'h00, lo});
    app_en = 0; out_inv = 0; out_rev = 0;
    new_block();

    // R12 LRC only
    crc_en = 0;
    send_str();
    app_en = 1;
    cyc();
    chk("R12 lrc byte", {8'h00, app_byte}, 16'h0031);
    app_req = 1; cyc(); app_req = 0;
    chk("R12 lrc done after one", {15'd0, app_done}, 16'd1);
    app_en = 0;
    new_block();

    // R12 no check enabled
    lrc_en = 0; app_en = 1;
    cyc(); cyc(); cyc();
    chk("R12 nothing appended", {15'd0, app_vld}, 16'd0);
    chk("R12 never done", {15'd0, app_done}, 16'd0);
    app_en = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule